// File: doc/BRIEF.md
# CAN Differential Level Digitizer

This block turns two raw parallel ADC streams, one sampling the CAN high wire and one sampling the CAN low wire, into a clean logic-level view of the bus. A new sample pair arrives on every cycle of a single 50 MHz clock. Each bus goes straight into a register stage. The block then forms the signed differential level and smooths it with a moving average over the last 8 or 16 differences. A two-threshold comparator with hysteresis decides between dominant and recessive.

The output is one bus-state bit, where 0 means dominant and 1 means recessive. A one-cycle strobe marks every change of that bit, and a companion bit gives the new level so that a downstream edge-timestamping unit can record transitions. The smoothed level and its validity flag are also brought out. The averaging window is picked by a mode input, and both thresholds are programmable as signed values.

Top module: `cdl_digitizer`

## Requirements
- R1: While reset is high and after its release, `bus_level` is 1 (recessive), `edge_stb` is 0 and `avg_valid` is 0 until the averaging window has filled.
- R2: Each ADC bus is captured by a register fed directly from its port. The differential value is the high sample minus the low sample, held as a signed 13-bit number that may be negative.
- R3: With `win16` = 0, `avg_level` is the floor of the sum of the last 8 differential values divided by 8 (arithmetic shift right by 3).
- R4: With `win16` = 1, `avg_level` is the floor of the sum of the last 16 differential values divided by 16 (arithmetic shift right by 4). The internal sum never leaves the range of 16 full-scale differences.
- R5: A sample pair present at clock edge k is reflected in `avg_level` after edge k+2. The first edge after reset release counts as edge 1. `avg_valid` first rises after edge N+2, where N is the window length.
- R6: `bus_level` goes from 1 to 0 only at the edge following a valid `avg_level` that is strictly greater than `thr_hi`. A value equal to `thr_hi` does not switch it.
- R7: `bus_level` goes from 0 to 1 only at the edge following a valid `avg_level` that is strictly less than `thr_lo`. Between the two thresholds the level holds.
- R8: While `avg_valid` is 0, `bus_level` does not change at the next edge.
- R9: `edge_stb` is 1 for exactly the cycle after each change of `bus_level` and is 0 otherwise. When it is 1, `edge_level` equals the new value of `bus_level`.
- R10: A change of `win16` restarts the window. `avg_valid` is 0 from the next edge until N new differential values have been absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz sample clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_smp | input | 12 | Unsigned ADC sample of the CAN high wire |
| lo_smp | input | 12 | Unsigned ADC sample of the CAN low wire |
| win16 | input | 1 | Window select: 0 = 8 samples, 1 = 16 samples |
| thr_hi | input | 13 | Signed upper threshold (switch to dominant) |
| thr_lo | input | 13 | Signed lower threshold (switch to recessive) |
| bus_level | output | 1 | Bus state: 0 dominant, 1 recessive |
| edge_stb | output | 1 | One-cycle pulse on each change of `bus_level` |
| edge_level | output | 1 | New level, valid when `edge_stb` is 1 |
| avg_valid | output | 1 | Averaged level is valid |
| avg_level | output | 13 | Signed averaged differential level |

## Verification
The hardest situation to reach is an averaged level that sits exactly on a threshold, or that wanders between the two thresholds after the level has already flipped. Random noise almost never lands there. Directed phases therefore hold a constant differential equal to `thr_hi`, then one count above it, then equal to and one count below `thr_lo`, so each strict comparison is hit exactly. The random phases add single-sample spikes that the average must absorb, and they flip `win16` mid-stream to force a window restart while edges are still in flight.

// File: rtl/cdl_pkg.sv
package cdl_pkg;

    localparam int ADC_W       = 12;
    localparam int DIFF_W      = ADC_W + 1;
    localparam int LANES       = 2;

    typedef logic signed [DIFF_W-1:0] diff_t;

    typedef enum logic {
        BUS_DOMINANT  = 1'b0,
        BUS_RECESSIVE = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic  vld;
        diff_t val;
    } diff_smp_t;

    function automatic diff_t high_minus_low(input logic [ADC_W-1:0] h,
                                             input logic [ADC_W-1:0] l);
        return diff_t'($signed({1'b0, h}) - $signed({1'b0, l}));
    endfunction

endpackage

// File: rtl/cdl_capture.sv
module cdl_capture
    import cdl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ADC_W-1:0] hi_i,
    input  logic [ADC_W-1:0] lo_i,
    output diff_smp_t        diff_o
);

    logic [ADC_W-1:0] lane_in [LANES];
    logic [ADC_W-1:0] lane_q  [LANES];
    logic             cap_vld_q;

    assign lane_in[0] = hi_i;
    assign lane_in[1] = lo_i;

    // Port-to-flop capture, no logic in front (R2)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            lane_q[g] <= lane_in[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_vld_q  <= 1'b0;
            diff_o.vld <= 1'b0;
            diff_o.val <= '0;
        end else begin
            cap_vld_q  <= 1'b1;
            diff_o.vld <= cap_vld_q;
            diff_o.val <= high_minus_low(lane_q[0], lane_q[1]);
        end
    end

    // R2
    diff_follows_capture_chk: assert property (@(posedge clk) disable iff (rst)
        diff_o.vld |-> $past(cap_vld_q));

endmodule

// File: rtl/cdl_window_avg.sv
module cdl_window_avg
    import cdl_pkg::*;
#(
    parameter int LOG_SHORT = 3,
    parameter int LOG_LONG  = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      win_long_i,
    input  diff_smp_t d_i,
    output diff_t     avg_o,
    output logic      avg_vld_o
);

    localparam int DEPTH     = 1 << LOG_LONG;
    localparam int SHORT_LEN = 1 << LOG_SHORT;
    localparam int SUM_W     = DIFF_W + LOG_LONG;
    localparam int CNT_W     = LOG_LONG + 1;
    localparam int SUM_LIM   = DEPTH * ((1 << ADC_W) - 1);

    typedef logic signed [SUM_W-1:0] sum_t;

    diff_t            sr_q [DEPTH];
    sum_t             sum_q, sum_n;
    logic [CNT_W-1:0] cnt_q, cnt_n, win_len;
    logic             mode_q;
    logic             restart, full;
    diff_t            tap;
    sum_t             d_ext, tap_ext;

    always_comb begin
        win_len = win_long_i ? CNT_W'(DEPTH) : CNT_W'(SHORT_LEN);
        restart = (win_long_i != mode_q);
        full    = (cnt_q == win_len);
        tap     = win_long_i ? sr_q[DEPTH-1] : sr_q[SHORT_LEN-1];
        d_ext   = {{(SUM_W-DIFF_W){d_i.val[DIFF_W-1]}}, d_i.val};
        tap_ext = {{(SUM_W-DIFF_W){tap[DIFF_W-1]}}, tap};

        sum_n = sum_q;
        cnt_n = cnt_q;
        if (restart) begin
            sum_n = d_i.vld ? d_ext : '0;
            cnt_n = d_i.vld ? CNT_W'(1) : '0;
        end else if (d_i.vld) begin
            if (full) begin
                sum_n = sum_q + d_ext - tap_ext;
            end else begin
                sum_n = sum_q + d_ext;
                cnt_n = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (d_i.vld) sr_q[0] <= d_i.val;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_tap
        always_ff @(posedge clk) begin
            if (d_i.vld) sr_q[g] <= sr_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q     <= '0;
            cnt_q     <= '0;
            mode_q    <= 1'b0;
            avg_o     <= '0;
            avg_vld_o <= 1'b0;
        end else begin
            sum_q     <= sum_n;
            cnt_q     <= cnt_n;
            mode_q    <= win_long_i;
            avg_o     <= win_long_i ? diff_t'(sum_n >>> LOG_LONG)
                                    : diff_t'(sum_n >>> LOG_SHORT);
            avg_vld_o <= (cnt_n == win_len);
        end
    end

    // R4
    sum_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sum_q <= SUM_LIM) && (sum_q >= -SUM_LIM));

    // R10
    restart_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (win_long_i != mode_q) |=> !avg_vld_o);

    // R5
    valid_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(avg_vld_o) |-> $past(d_i.vld));

endmodule

// File: rtl/cdl_hyst.sv
module cdl_hyst
    import cdl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  diff_t avg_i,
    input  logic  avg_vld_i,
    input  diff_t thr_hi_i,
    input  diff_t thr_lo_i,
    output logic  level_o,
    output logic  edge_stb_o,
    output logic  edge_level_o
);

    bus_state_e st_q, st_n;

    always_comb begin
        st_n = st_q;
        if (avg_vld_i) begin
            if (st_q == BUS_RECESSIVE && avg_i > thr_hi_i) st_n = BUS_DOMINANT;
            else if (st_q == BUS_DOMINANT && avg_i < thr_lo_i) st_n = BUS_RECESSIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= BUS_RECESSIVE;
            edge_stb_o   <= 1'b0;
            edge_level_o <= 1'b1;
        end else begin
            st_q       <= st_n;
            edge_stb_o <= (st_n != st_q);
            if (st_n != st_q) edge_level_o <= st_n;
        end
    end

    assign level_o = st_q;

    // R6
    dominant_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(level_o) |-> $past(avg_vld_i && (avg_i > thr_hi_i)));

    // R7
    recessive_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(level_o) |-> $past(avg_vld_i && (avg_i < thr_lo_i)));

    // R8
    hold_when_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !avg_vld_i |=> $stable(level_o));

    // R9
    strobe_marks_change_chk: assert property (@(posedge clk) disable iff (rst)
        edge_stb_o |-> (level_o != $past(level_o)) && (edge_level_o == level_o));

endmodule

// File: rtl/cdl_digitizer.sv
module cdl_digitizer
    import cdl_pkg::*;
#(
    parameter int LOG_SHORT = 3,
    parameter int LOG_LONG  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADC_W-1:0]         hi_smp,
    input  logic [ADC_W-1:0]         lo_smp,
    input  logic                     win16,
    input  logic signed [DIFF_W-1:0] thr_hi,
    input  logic signed [DIFF_W-1:0] thr_lo,
    output logic                     bus_level,
    output logic                     edge_stb,
    output logic                     edge_level,
    output logic                     avg_valid,
    output logic signed [DIFF_W-1:0] avg_level
);

    diff_smp_t diff_s;
    diff_t     avg_s;
    logic      avg_vld_s;

    cdl_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .hi_i   (hi_smp),
        .lo_i   (lo_smp),
        .diff_o (diff_s)
    );

    cdl_window_avg #(
        .LOG_SHORT (LOG_SHORT),
        .LOG_LONG  (LOG_LONG)
    ) u_avg (
        .clk        (clk),
        .rst        (rst),
        .win_long_i (win16),
        .d_i        (diff_s),
        .avg_o      (avg_s),
        .avg_vld_o  (avg_vld_s)
    );

    cdl_hyst u_hyst (
        .clk          (clk),
        .rst          (rst),
        .avg_i        (avg_s),
        .avg_vld_i    (avg_vld_s),
        .thr_hi_i     (thr_hi),
        .thr_lo_i     (thr_lo),
        .level_o      (bus_level),
        .edge_stb_o   (edge_stb),
        .edge_level_o (edge_level)
    );

    assign avg_valid = avg_vld_s;
    assign avg_level = avg_s;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> bus_level && !edge_stb && !avg_valid);

endmodule

// File: tb/cdl_digitizer_tb.sv
`timescale 1ns/1ps
module cdl_digitizer_tb_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [11:0]        hi_smp = 12'd2048;
    logic [11:0]        lo_smp = 12'd2048;
    logic               win16 = 1'b0;
    logic signed [12:0] thr_hi = 13'sd900;
    logic signed [12:0] thr_lo = 13'sd500;
    logic               bus_level, edge_stb, edge_level, avg_valid;
    logic signed [12:0] avg_level;

    always #10 clk = ~clk;

    cdl_digitizer dut_i (
        .clk(clk), .rst(rst), .hi_smp(hi_smp), .lo_smp(lo_smp), .win16(win16),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .bus_level(bus_level),
        .edge_stb(edge_stb), .edge_level(edge_level), .avg_valid(avg_valid),
        .avg_level(avg_level)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // expected-value state, derived from the requirements
    int m_level, m_stb, m_elvl, m_avg, m_avg_vld, m_prev_mode;
    int m_cap_h, m_cap_l, m_cap_vld, m_d, m_d_vld;
    int hist [16];
    int h_wp, h_cnt;
    string lvl_tag = "R6";

    function automatic int win_len(input int md);
        return md ? 16 : 8;
    endfunction

    function automatic int clamp12(input int v);
        if (v < 0) return 0;
        if (v > 4095) return 4095;
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_level = 1; m_stb = 0; m_elvl = 1; m_avg = 0; m_avg_vld = 0;
        m_prev_mode = 0; m_cap_h = 0; m_cap_l = 0; m_cap_vld = 0;
        m_d = 0; m_d_vld = 0; h_wp = 0; h_cnt = 0;
    endtask

    // predicts the outputs after the coming edge
    task automatic model_step();
        int md, n, s;
        md = int'(win16);
        m_stb = 0;
        if (m_avg_vld != 0) begin
            if (m_level == 1 && m_avg > int'(thr_hi)) begin
                m_level = 0; m_stb = 1; m_elvl = 0;
            end else if (m_level == 0 && m_avg < int'(thr_lo)) begin
                m_level = 1; m_stb = 1; m_elvl = 1;
            end
        end
        if (md != m_prev_mode) h_cnt = 0;
        if (m_d_vld != 0) begin
            hist[h_wp] = m_d;
            h_wp = (h_wp + 1) % 16;
            h_cnt++;
        end
        n = win_len(md);
        m_avg_vld = (h_cnt >= n) ? 1 : 0;
        if (h_cnt > 0) begin
            s = 0;
            for (int k = 0; k < n && k < h_cnt; k++) s += hist[(h_wp + 15 - k) % 16];
            m_avg = s >>> (md ? 4 : 3);
        end else begin
            m_avg = 0;
        end
        m_prev_mode = md;
        m_d = m_cap_h - m_cap_l;
        m_d_vld = m_cap_vld;
        m_cap_h = int'(hi_smp);
        m_cap_l = int'(lo_smp);
        m_cap_vld = 1;
    endtask

    task automatic check_outputs();
        string atag;
        atag = win16 ? "R4" : "R3";
        chk(lvl_tag, int'(bus_level), m_level);
        chk("R9", int'(edge_stb), m_stb);
        if (m_stb != 0) chk("R9", int'(edge_level), m_elvl);
        chk("R5", int'(avg_valid), m_avg_vld);
        if (m_avg_vld != 0) chk(atag, int'(avg_level), m_avg);
    endtask

    task automatic step(input int h, input int l);
        hi_smp = 12'(clamp12(h));
        lo_smp = 12'(clamp12(l));
        model_step();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic drive_diff(input int d, input int cycles);
        for (int i = 0; i < cycles; i++) step(2048 + d / 2, 2048 - (d - d / 2));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        // R1
        chk("R1", int'(bus_level), 1);
        chk("R1", int'(edge_stb), 0);
        chk("R1", int'(avg_valid), 0);
        rst = 1'b0;
    endtask

    task automatic random_frames(input int count);
        int lvl, run, base, noise;
        lvl = 1;
        for (int f = 0; f < count; f++) begin
            lvl = 1 - lvl;
            run = 5 + int'($urandom % 36);
            base = (lvl == 0) ? 1600 : 0;
            for (int i = 0; i < run; i++) begin
                noise = int'($urandom % 301) - 150;
                if ($urandom % 20 == 0) noise += ($urandom % 2) ? 1200 : -1200;
                step(2048 + (base + noise) / 2 + int'($urandom % 9) - 4,
                     2048 - (base + noise) / 2);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd24681));
        model_reset();
        @(negedge clk);
        do_reset();

        // R5: fill latency and first valid with the short window
        drive_diff(2000, 14);

        // R6 boundary: average equal to thr_hi must not switch
        do_reset();
        lvl_tag = "R6";
        drive_diff(900, 20);
        chk("R6", int'(bus_level), 1);
        drive_diff(901, 12);
        chk("R6", int'(bus_level), 0);

        // R7 boundary: average equal to thr_lo holds, in-between holds
        lvl_tag = "R7";
        drive_diff(700, 12);
        chk("R7", int'(bus_level), 0);
        drive_diff(500, 12);
        chk("R7", int'(bus_level), 0);
        drive_diff(499, 12);
        chk("R7", int'(bus_level), 1);

        // R2: negative differential (low above high)
        lvl_tag = "R2";
        drive_diff(-1500, 12);
        chk("R2", int'(avg_level), -1500);
        step(1000, 3000);
        step(4095, 0);
        drive_diff(-7, 12);

        // R8: during window refill after reset the level must hold
        lvl_tag = "R8";
        do_reset();
        drive_diff(3000, 9);
        chk("R8", int'(bus_level), 1);
        drive_diff(3000, 4);

        // R3 random traffic with the short window
        lvl_tag = "R6";
        random_frames(40);

        // R10: switch to the long window mid-stream
        lvl_tag = "R10";
        win16 = 1'b1;
        step(2048, 2048);
        chk("R10", int'(avg_valid), 0);
        random_frames(40);

        // R4 full-scale window sum
        drive_diff(4095, 20);
        drive_diff(-4095, 20);
        win16 = 1'b0;
        random_frames(20);

        // threshold change under random traffic
        thr_hi = 13'sd400;
        thr_lo = -13'sd100;
        random_frames(20);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule